// File: doc/BRIEF.md
# Banked Cross-Bus Access Bridge

This bridge lets an 8-bit secondary processor reach the 24-bit byte address space of a 16-bit main processor. The top half of the secondary address space (0x8000 to 0xFFFF) is a 32 KB window. The bridge builds the main address by placing a 9-bit bank register above the low 15 bits of the secondary address. Main addresses in the top region fold onto a single 64 KB work-RAM image. A small port page in the secondary map reaches the video controller and the sound generator over the same path.

Each accepted access works through four steps:
- It waits a fixed number of secondary clock periods to win the main bus.
- It runs one byte transfer on the 16-bit main bus.
- It acknowledges the requester.
- It charges a fixed stall to the main processor. The stall is counted in main clock periods and shown on a stall output.

While an access or its stall is still running, new requests are held off. An illegal port offset sets a sticky lockup flag. Secondary clock periods are marked by `sec_ce_i` and main clock periods by `main_ce_i`. Both are enables on the single bridge clock.

Top module: `xbus_bridge`

## Requirements
- R1: A request at secondary address 0x8000 to 0xFFFF drives `m_addr_o` = {bank, addr[14:0]} with `m_dev_o` = 0 (memory), provided that value is below 0xE00000.
- R2: If the composed window address is 0xE00000 or higher, `m_addr_o` = 0xFF0000 OR'd with its low 16 bits.
- R3: After an access is accepted, `m_req_o` rises only after exactly 3 cycles in which `sec_ce_i` was high.
- R4: From the cycle after acceptance, `stall_o` stays high for exactly 8 cycles in which `main_ce_i` is high, then falls. This holds for both window and port accesses.
- R5: On the main bus, an even byte address uses the upper lane [15:8] with `m_be_o` = 2'b10. An odd byte address uses the lower lane [7:0] with `m_be_o` = 2'b01. Write data is copied to both lanes, and read data is taken from the addressed lane.
- R6: Secondary address 0x7F00 to 0x7F1F (offset = addr[7:0]) drives `m_addr_o` = 0xC00000 + offset. `m_dev_o` is 1 (video) for an offset below 0x10 and 2 (sound) otherwise. These accesses use the same wait and stall as window accesses.
- R7: A port-page address whose offset has any of bits 7:5 set is illegal. It starts no bus cycle and no stall. It is acknowledged in the next cycle with `rdata_o` = 0xFF. It sets `lock_o`, which stays high until reset.
- R8: Any other address (0x0000 to 0x7EFF) is acknowledged in the next cycle with `rdata_o` = 0xFF. It starts no bus cycle and no stall and leaves `lock_o` unchanged.
- R9: The bank register resets to 0. A bank write in the same cycle that a request is accepted does not change that access. Later accesses use the new bank.
- R10: While an access or its stall is in progress, a pending request gets no `ack_o` and no `m_req_o` until `stall_o` is low.
- R11: `ack_o` is a one-cycle pulse, and `rdata_o` is valid during it. `m_req_o` stays high with a stable address until `m_ack_i`.
- R12: After reset, `ack_o`, `m_req_o`, `stall_o` and `lock_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bridge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_ce_i | input | 1 | Marks a secondary clock period |
| main_ce_i | input | 1 | Marks a main clock period |
| req_i | input | 1 | Secondary access request, held until `ack_o` |
| we_i | input | 1 | Secondary write when high |
| addr_i | input | 16 | Secondary address |
| wdata_i | input | 8 | Secondary write byte |
| ack_o | output | 1 | Access done, one cycle |
| rdata_o | output | 8 | Read byte |
| bank_we_i | input | 1 | Bank register write strobe |
| bank_i | input | 9 | New bank value |
| m_req_o | output | 1 | Main bus cycle request |
| m_we_o | output | 1 | Main bus write |
| m_addr_o | output | 24 | Main bus byte address |
| m_be_o | output | 2 | Main bus byte lanes |
| m_wdata_o | output | 16 | Main bus write data |
| m_rdata_i | input | 16 | Main bus read data |
| m_ack_i | input | 1 | Main bus cycle done |
| m_dev_o | output | 2 | Target: 0 memory, 1 video, 2 sound |
| stall_o | output | 1 | Main processor stalled |
| lock_o | output | 1 | Sticky illegal-access flag |

## Verification
Two events can fall in the same cycle:
- a request held off by the stall is accepted on the edge where the stall count reaches zero;
- a bank register write lands on that same edge.

The bench provokes this with a slow main clock enable and an immediate second request. It writes a new bank exactly in the first cycle that `stall_o` reads low. It then judges the result by the second access's main address, which must still carry the old bank. A third access must show the new bank. Across the held-off interval, `ack_o` and `m_req_o` must stay low while the stall of the first access still totals 8 main periods.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    DEV_MEM   = 2'd0,
    DEV_VIDEO = 2'd1,
    DEV_SOUND = 2'd2,
    DEV_NONE  = 2'd3
  } dev_e;

  typedef enum logic [1:0] {
    CLS_WIN,
    CLS_PORT,
    CLS_BAD,
    CLS_OPEN
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_BUS,
    ST_ACK
  } st_e;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int                   SEC_AW    = 16,
  parameter int                   WIN_W     = 15,
  parameter int                   BANK_W    = 9,
  parameter int                   MAIN_AW   = 24,
  parameter int                   RAM_W     = 16,
  parameter int                   PORT_W    = 5,
  parameter int                   VID_SPAN  = 16,
  parameter logic [SEC_AW-9:0]    PORT_PAGE = 'h7F,
  parameter logic [MAIN_AW-1:0]   FOLD_BASE = 24'hE00000,
  parameter logic [MAIN_AW-1:0]   RAM_BASE  = 24'hFF0000,
  parameter logic [MAIN_AW-1:0]   VID_BASE  = 24'hC00000
) (
  input  logic [SEC_AW-1:0]  addr_i,
  input  logic [BANK_W-1:0]  bank_i,
  output cls_e               cls_o,
  output dev_e               dev_o,
  output logic [MAIN_AW-1:0] maddr_o
);
  logic [MAIN_AW-1:0] full;
  logic [7:0]         off;
  logic               in_win;
  logic               in_page;
  logic               port_ok;

  assign full    = {bank_i, addr_i[WIN_W-1:0]};
  assign off     = addr_i[7:0];
  assign in_win  = addr_i[SEC_AW-1];
  assign in_page = (addr_i[SEC_AW-1:8] == PORT_PAGE);
  assign port_ok = ((off >> PORT_W) == 8'd0);

  always_comb begin
    cls_o   = CLS_OPEN;
    dev_o   = DEV_NONE;
    maddr_o = '0;
    if (in_win) begin
      cls_o = CLS_WIN;
      dev_o = DEV_MEM;
      if (full >= FOLD_BASE)
        maddr_o = RAM_BASE | {{(MAIN_AW-RAM_W){1'b0}}, full[RAM_W-1:0]};
      else
        maddr_o = full;
    end else if (in_page) begin
      if (port_ok) begin
        cls_o   = CLS_PORT;
        dev_o   = (int'(off) < VID_SPAN) ? DEV_VIDEO : DEV_SOUND;
        maddr_o = VID_BASE | {{(MAIN_AW-PORT_W){1'b0}}, off[PORT_W-1:0]};
      end else begin
        cls_o = CLS_BAD;
      end
    end
  end
endmodule

// File: rtl/xbus_count.sv
module xbus_count #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int SEC_AW     = 16,
  parameter int WIN_W      = 15,
  parameter int BANK_W     = 9,
  parameter int DW         = 8,
  parameter int RAM_W      = 16,
  parameter int PORT_W     = 5,
  parameter int VID_SPAN   = 16,
  parameter int ARB_WAIT   = 3,
  parameter int MAIN_STALL = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sec_ce_i,
  input  logic                     main_ce_i,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [SEC_AW-1:0]        addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic                     ack_o,
  output logic [DW-1:0]            rdata_o,
  input  logic                     bank_we_i,
  input  logic [BANK_W-1:0]        bank_i,
  output logic                     m_req_o,
  output logic                     m_we_o,
  output logic [BANK_W+WIN_W-1:0]  m_addr_o,
  output logic [1:0]               m_be_o,
  output logic [2*DW-1:0]          m_wdata_o,
  input  logic [2*DW-1:0]          m_rdata_i,
  input  logic                     m_ack_i,
  output logic [1:0]               m_dev_o,
  output logic                     stall_o,
  output logic                     lock_o
);
  localparam int MAIN_AW  = BANK_W + WIN_W;
  localparam int ARB_CW   = $clog2(ARB_WAIT + 1);
  localparam int STALL_CW = $clog2(MAIN_STALL + 1);

  st_e                st_q;
  logic [BANK_W-1:0]  bank_q;
  logic [MAIN_AW-1:0] maddr_q;
  dev_e               dev_q;
  logic               we_q;
  logic [DW-1:0]      wdata_q;
  logic [DW-1:0]      rdata_q;
  logic               lock_q;

  cls_e               dec_cls;
  dev_e               dec_dev;
  logic [MAIN_AW-1:0] dec_addr;

  logic               bus_cls;
  logic               can_start;
  logic               accept_bus;
  logic               accept_nb;
  logic [ARB_CW-1:0]  arb_cnt;
  logic               arb_zero;
  logic [STALL_CW-1:0] stall_cnt;
  logic               stall_zero;
  logic [DW-1:0]      lane_rd;

  xbus_decode #(
    .SEC_AW  (SEC_AW),
    .WIN_W   (WIN_W),
    .BANK_W  (BANK_W),
    .MAIN_AW (MAIN_AW),
    .RAM_W   (RAM_W),
    .PORT_W  (PORT_W),
    .VID_SPAN(VID_SPAN)
  ) u_decode (
    .addr_i (addr_i),
    .bank_i (bank_q),
    .cls_o  (dec_cls),
    .dev_o  (dec_dev),
    .maddr_o(dec_addr)
  );

  assign bus_cls    = (dec_cls == CLS_WIN) || (dec_cls == CLS_PORT);
  assign can_start  = (st_q == ST_IDLE) && req_i && stall_zero;
  assign accept_bus = can_start && bus_cls;
  assign accept_nb  = can_start && !bus_cls;

  // arbitration wait, counted in secondary periods
  xbus_count #(.W(ARB_CW)) u_arb_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept_bus),
    .load_val_i(ARB_CW'(ARB_WAIT)),
    .tick_i    (sec_ce_i && st_q == ST_ARB),
    .cnt_o     (arb_cnt),
    .zero_o    (arb_zero)
  );

  // stall charged to the main processor, counted in main periods
  xbus_count #(.W(STALL_CW)) u_stall_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept_bus),
    .load_val_i(STALL_CW'(MAIN_STALL)),
    .tick_i    (main_ce_i),
    .cnt_o     (stall_cnt),
    .zero_o    (stall_zero)
  );

  // big-endian lanes: even byte on the upper half
  generate
    if (DW == 8) begin : g_lane8
      assign lane_rd = maddr_q[0] ? m_rdata_i[DW-1:0] : m_rdata_i[2*DW-1:DW];
    end else begin : g_lane_wide
      assign lane_rd = m_rdata_i[DW-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      bank_q  <= '0;
      maddr_q <= '0;
      dev_q   <= DEV_NONE;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (bank_we_i) bank_q <= bank_i;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_bus) begin
            st_q    <= ST_ARB;
            maddr_q <= dec_addr;
            dev_q   <= dec_dev;
            we_q    <= we_i;
            wdata_q <= wdata_i;
          end else if (accept_nb) begin
            st_q    <= ST_ACK;
            rdata_q <= '1;
            if (dec_cls == CLS_BAD) lock_q <= 1'b1;
          end
        end
        ST_ARB: begin
          if (sec_ce_i && !arb_zero && arb_cnt == ARB_CW'(1)) st_q <= ST_BUS;
        end
        ST_BUS: begin
          if (m_ack_i) begin
            rdata_q <= lane_rd;
            st_q    <= ST_ACK;
          end
        end
        ST_ACK: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o     = (st_q == ST_ACK);
  assign rdata_o   = rdata_q;
  assign m_req_o   = (st_q == ST_BUS);
  assign m_we_o    = we_q;
  assign m_addr_o  = maddr_q;
  assign m_be_o    = maddr_q[0] ? 2'b01 : 2'b10;
  assign m_wdata_o = {wdata_q, wdata_q};
  assign m_dev_o   = dev_q;
  assign stall_o   = !stall_zero;
  assign lock_o    = lock_q;
endmodule

// File: rtl/xbus_bridge_chk.sv
module xbus_bridge_chk #(
  parameter int ARB_WAIT = 3,
  parameter int AW       = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sec_ce_i,
  input logic          ack_o,
  input logic          m_req_o,
  input logic          m_ack_i,
  input logic [AW-1:0] m_addr_o,
  input logic [1:0]    m_dev_o,
  input logic          stall_o,
  input logic          lock_o,
  input logic          accept
);
  logic       in_arb;
  logic [7:0] arb_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_arb   <= 1'b0;
      arb_seen <= '0;
    end else if (accept) begin
      in_arb   <= 1'b1;
      arb_seen <= '0;
    end else if (m_req_o) begin
      in_arb   <= 1'b0;
    end else if (in_arb && sec_ce_i) begin
      arb_seen <= arb_seen + 8'd1;
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);  // R11
  AST_MREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && !m_ack_i) |=> (m_req_o && $stable(m_addr_o)));  // R11
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);  // R7
  AST_RAM_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_dev_o == 2'd0 && m_addr_o >= AW'(24'hE00000)) |-> (m_addr_o[AW-1:16] == '1));  // R2
  AST_STALL_FROM_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(accept));  // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> !stall_o);  // R10
  AST_ARB_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_req_o) |-> (arb_seen == 8'(ARB_WAIT)));  // R3
endmodule

bind xbus_bridge xbus_bridge_chk #(
  .ARB_WAIT(ARB_WAIT),
  .AW      (BANK_W + WIN_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sec_ce_i(sec_ce_i),
  .ack_o   (ack_o),
  .m_req_o (m_req_o),
  .m_ack_i (m_ack_i),
  .m_addr_o(m_addr_o),
  .m_dev_o (m_dev_o),
  .stall_o (stall_o),
  .lock_o  (lock_o),
  .accept  (accept_bus)
);

// File: tb/xbus_bridge_bench.sv
`timescale 1ns/1ps
module xbus_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sec_ce = 1'b0, main_ce = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ack_o;
  logic [7:0]  rdata_o;
  logic        bank_we_i = 1'b0;
  logic [8:0]  bank_i = '0;
  logic        m_req_o, m_we_o;
  logic [23:0] m_addr_o;
  logic [1:0]  m_be_o;
  logic [15:0] m_wdata_o;
  logic [15:0] m_rdata_i = '0;
  logic        m_ack_i = 1'b0;
  logic [1:0]  m_dev_o;
  logic        stall_o, lock_o;

  int checks = 0, fails = 0;
  int sdiv = 1, mdiv = 1, cyc = 0;
  int stall_seen = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    sec_ce  <= ((cyc + 1) % sdiv) == 0;
    main_ce <= ((cyc + 1) % mdiv) == 0;
  end

  always @(posedge clk) if (stall_o && main_ce) stall_seen = stall_seen + 1;

  xbus_bridge u_xbus_bridge (
    .clk_i(clk), .rst_ni(rst_ni), .sec_ce_i(sec_ce), .main_ce_i(main_ce),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ack_o(ack_o), .rdata_o(rdata_o), .bank_we_i(bank_we_i), .bank_i(bank_i),
    .m_req_o(m_req_o), .m_we_o(m_we_o), .m_addr_o(m_addr_o), .m_be_o(m_be_o),
    .m_wdata_o(m_wdata_o), .m_rdata_i(m_rdata_i), .m_ack_i(m_ack_i),
    .m_dev_o(m_dev_o), .stall_o(stall_o), .lock_o(lock_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] win_addr(input logic [8:0] bank, input logic [15:0] a);
    logic [23:0] full;
    full = {bank, a[14:0]};
    return (full >= 24'hE00000) ? (24'hFF0000 | {8'h00, full[15:0]}) : full;
  endfunction

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    return {a[8:1] + 8'h11, ~a[8:1]};
  endfunction

  task automatic set_bank(input logic [8:0] b);
    bank_we_i = 1'b1; bank_i = b;
    @(negedge clk);
    bank_we_i = 1'b0;
  endtask

  task automatic start(input logic [15:0] a, input logic we, input logic [7:0] wd);
    addr_i = a; we_i = we; wdata_i = wd; req_i = 1'b1;
  endtask

  // called at the negedge of the accepting cycle
  task automatic run_xfer(input logic [23:0] ea, input logic [1:0] edev, input string tag);
    int arbn = 0;
    int g = 0;
    logic [15:0] w;
    stall_seen = 0;
    @(negedge clk);
    bank_we_i = 1'b0;
    while (!m_req_o && g < 1000) begin
      if (sec_ce) arbn++;
      @(negedge clk);
      g++;
    end
    chk(arbn == 3, "R3 arbitration wait", arbn, 3);
    chk(m_addr_o == ea, tag, m_addr_o, ea);
    chk(m_dev_o == edev, {tag, " dev"}, m_dev_o, edev);
    chk(m_we_o == we_i, "R5 write flag", m_we_o, we_i);
    chk(m_be_o == (ea[0] ? 2'b01 : 2'b10), "R5 lane strobe", m_be_o, ea[0] ? 2'b01 : 2'b10);
    if (we_i) chk(m_wdata_o == {wdata_i, wdata_i}, "R5 write lanes", m_wdata_o, {wdata_i, wdata_i});
    w = mem_word(m_addr_o);
    m_rdata_i = w;
    m_ack_i = 1'b1;
    @(negedge clk);
    m_ack_i = 1'b0;
    chk(ack_o == 1'b1, "R11 ack pulse", ack_o, 1);
    if (!we_i) chk(rdata_o == (ea[0] ? w[7:0] : w[15:8]), "R5 read lane", rdata_o, ea[0] ? w[7:0] : w[15:8]);
    req_i = 1'b0;
    @(negedge clk);
    chk(ack_o == 1'b0, "R11 ack one cycle", ack_o, 0);
  endtask

  task automatic wait_stall();
    int g = 0;
    while (stall_o && g < 5000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
    chk(stall_seen == 8, "R4 main stall periods", stall_seen, 8);
  endtask

  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                        input logic [23:0] ea, input logic [1:0] edev, input string tag);
    start(a, we, wd);
    run_xfer(ea, edev, tag);
    wait_stall();
  endtask

  task automatic nobus(input logic [15:0] a, input logic exp_lock, input string tag);
    start(a, 1'b0, 8'h00);
    @(negedge clk);
    chk(ack_o == 1'b1, {tag, " ack"}, ack_o, 1);
    chk(m_req_o == 1'b0, {tag, " no bus"}, m_req_o, 0);
    chk(stall_o == 1'b0, {tag, " no stall"}, stall_o, 0);
    chk(rdata_o == 8'hFF, {tag, " data"}, rdata_o, 8'hFF);
    chk(lock_o == exp_lock, {tag, " lock"}, lock_o, exp_lock);
    req_i = 1'b0;
    @(negedge clk);
    chk(ack_o == 1'b0, "R11 ack one cycle", ack_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [8:0]  banks [5] = '{9'h000, 9'h001, 9'h1BF, 9'h1C0, 9'h1FF};
    logic [15:0] offs  [3] = '{16'h8001, 16'hFFFE, 16'h9235};
    int sds [3] = '{1, 2, 3};
    int mds [2] = '{1, 4};
    bit held_ok;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ack_o && !m_req_o && !stall_o && !lock_o, "R12 reset state",
        {ack_o, m_req_o, stall_o, lock_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 bank resets to zero
    access(16'h8002, 1'b0, 8'h00, 24'h000002, 2'd0, "R9 reset bank");

    // R1 R2 window sweep
    foreach (sds[i]) foreach (mds[j]) begin
      sdiv = sds[i]; mdiv = mds[j];
      foreach (banks[k]) begin
        set_bank(banks[k]);
        foreach (offs[n]) begin
          logic [23:0] ea;
          ea = win_addr(banks[k], offs[n]);
          access(offs[n], n == 2, 8'h5C ^ 8'(n), ea, 2'd0,
                 ea >= 24'hFF0000 ? "R2 fold address" : "R1 window address");
        end
      end
    end

    // R6 port page sweep
    sdiv = 2; mdiv = 3;
    for (int off = 0; off < 32; off++) begin
      access(16'h7F00 | 16'(off), off[0], 8'(off), 24'hC00000 | 24'(off),
             (off < 16) ? 2'd1 : 2'd2, "R6 port address");
    end

    // R8 unmapped
    sdiv = 1; mdiv = 1;
    nobus(16'h0000, 1'b0, "R8 unmapped");
    nobus(16'h7EFF, 1'b0, "R8 unmapped");
    nobus(16'h4000, 1'b0, "R8 unmapped");

    // R7 illegal port offsets
    nobus(16'h7F20, 1'b1, "R7 illegal");
    nobus(16'h7FE0, 1'b1, "R7 illegal");
    nobus(16'h7F40, 1'b1, "R7 illegal");
    access(16'h7F04, 1'b0, 8'h00, 24'hC00004, 2'd1, "R6 port address");
    chk(lock_o == 1'b1, "R7 lock sticky", lock_o, 1);

    // R10 hold-off and R9 bank write on the accepting edge
    sdiv = 1; mdiv = 6;
    set_bank(9'h005);
    start(16'h8010, 1'b0, 8'h00);
    run_xfer(win_addr(9'h005, 16'h8010), 2'd0, "R1 window address");
    start(16'h8020, 1'b0, 8'h00);
    held_ok = 1'b1;
    begin
      int g = 0;
      while (stall_o && g < 5000) begin
        if (ack_o || m_req_o) held_ok = 1'b0;
        @(negedge clk);
        g++;
      end
    end
    chk(held_ok, "R10 request held off", held_ok, 1);
    chk(stall_seen == 8, "R4 main stall periods", stall_seen, 8);
    bank_we_i = 1'b1; bank_i = 9'h0AA;
    run_xfer(win_addr(9'h005, 16'h8020), 2'd0, "R9 old bank on accept edge");
    wait_stall();
    access(16'h8020, 1'b0, 8'h00, win_addr(9'h0AA, 16'h8020), 2'd0, "R9 new bank");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule